// File: doc/BRIEF.md
# Configurable Interrupt Source Router

This block steers internal interrupt request lines onto sixteen legacy IRQ outputs. Each source belongs to one of two classes. The device class carries interrupts from internal peripherals such as a USB controller. The timer class carries timer and general-purpose pin interrupts. Every source has its own 4-bit group selector. A selector value from 1 to 15 sends the source to the IRQ output with that number. The value 0 switches the source off.

The selectors sit in two 32-bit mapping words, one per class, and are reached through a simple register port. Writes are synchronous and reads are combinational. Source inputs are level-sensitive. All sources that select the same group are ORed together, and the result is registered before it drives the IRQ outputs. A priority controller downstream sees one clean level per IRQ line.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every selector reads 0 and `irq` is 0.
- R2: The device-class mapping word is at address 0 and the timer-class word is at address 1. A write stores `cfg_wdata` on the clock edge, and a read of that address returns the stored value exactly.
- R3: Source k of a class uses the selector at bits 4k+3:4k of its class word; for example, device source 2 uses bits 11:8. When the source is high and its selector holds g (1..15), `irq[g]` goes high one clock edge after the source is sampled.
- R4: A source whose selector is 0 drives no IRQ output, whatever level it has.
- R5: When several sources, of either class, select the same group, that group's output is the OR of those sources.
- R6: `irq[0]` is never asserted.
- R7: A write to address 2 or 3 changes no mapping word and no output, and a read of those addresses returns 0.
- R8: A mapping write that takes effect at edge T is reflected on `irq` at edge T+1. At edge T itself, `irq` still uses the old mapping.
- R9: `irq[g]` stays high for as long as a mapped source is held high. It drops at the first edge that samples all of its sources low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| src_dev | input | 8 | Device-class interrupt sources, level-sensitive |
| src_tmr | input | 8 | Timer-class interrupt sources, level-sensitive |
| irq | output | 16 | Registered legacy IRQ outputs, bit n is IRQ n |

## Verification
The assertions assume that `cfg_we`, `cfg_addr`, `cfg_wdata` and the source vectors change only between active edges and are stable at each sampling edge. They also assume that a selector's value always names a valid group, which holds because the group count equals the selector range. The stimulus drives every input on the falling edge, keeps the write strobe to a single cycle, and holds sources steady across the edges being checked. The only writes to unused addresses are the deliberate ones that test that they are ignored.

// File: rtl/irq_router_pkg.sv
// Package: shared constants for the interrupt source router.
// Assumes two source classes, each decoded at its own word address.
package irq_router_pkg;
    localparam int NUM_CLS = 2;

    // Class identifiers; the value doubles as the mapping word address.
    typedef enum logic [0:0] {
        CLS_DEV = 1'b0,
        CLS_TMR = 1'b1
    } src_class_e;
endpackage

// File: rtl/irq_sel_bank.sv
// Module: irq_sel_bank
// Holds one class's packed group selectors (SEL_W bits per source) in a
// single register word at address BANK_ADDR. A write loads the word on the
// next clock edge. The read word is the stored selectors, zero-padded.
// Assumes N_SRC*SEL_W <= DATA_W.
module irq_sel_bank #(
    parameter int N_SRC     = 8,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int BANK_ADDR = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [N_SRC*SEL_W-1:0]  sel_flat,
    output logic [DATA_W-1:0]       rd_word
);
    localparam int FLD_W = N_SRC * SEL_W;
    localparam int PAD_W = DATA_W - FLD_W;

    logic                   hit;
    logic [FLD_W-1:0]       sel_q;

    // Decode a write aimed at this bank.
    assign hit = wr_en && (wr_addr == ADDR_W'(BANK_ADDR));

    // Selector storage: cleared by reset, loaded by a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (hit)
            sel_q <= wr_data[FLD_W-1:0];
    end

    assign sel_flat = sel_q;

    // Read word: selectors in the low bits, zeros above.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_word = {{PAD_W{1'b0}}, sel_q};
        end else begin : g_nopad
            assign rd_word = sel_q;
        end
    endgenerate

    AST_SEL_RESET: assert property (@(posedge clk)
        !rst_n |=> (sel_flat == '0)) else $error("selector not cleared");      // R1
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (sel_flat == $past(wr_data[FLD_W-1:0]))) else $error("load"); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(sel_flat)) else $error("selector moved");           // R7
endmodule

// File: rtl/irq_src_decode.sv
// Module: irq_src_decode
// Turns one class's sources and packed selectors into a per-group request
// vector. Group g is requested when any source is high and its selector is
// g. Group 0 is never requested, so a selector of 0 means disabled.
// Assumes N_GRP <= 2**SEL_W.
module irq_src_decode #(
    parameter int N_SRC = 8,
    parameter int SEL_W = 4,
    parameter int N_GRP = 16
) (
    input  logic [N_SRC-1:0]        src,
    input  logic [N_SRC*SEL_W-1:0]  sel_flat,
    output logic [N_GRP-1:0]        grp_req
);
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            if (g == 0) begin : g_off
                // Group 0 is the disable code and never requests.
                assign grp_req[g] = 1'b0;
            end else begin : g_on
                logic acc;
                // OR together every high source whose selector names this group.
                always_comb begin
                    acc = 1'b0;
                    for (int k = 0; k < N_SRC; k++)
                        if (src[k] && (sel_flat[k*SEL_W +: SEL_W] == SEL_W'(g)))
                            acc = 1'b1;
                end
                assign grp_req[g] = acc;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Routes two classes of level-sensitive interrupt sources onto N_GRP
// legacy IRQ lines through per-source group selectors held in one mapping
// word per class. The requests of both classes are ORed and registered, so
// a change of mapping cannot glitch an output within a cycle.
// Assumes inputs are synchronous to clk.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int SEL_W  = 4,
    parameter int N_GRP  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [N_SRC-1:0]  src_dev,
    input  logic [N_SRC-1:0]  src_tmr,
    output logic [N_GRP-1:0]  irq
);
    localparam int FLD_W = N_SRC * SEL_W;

    logic [N_SRC-1:0]  src_cls [NUM_CLS];
    logic [FLD_W-1:0]  sel_cls [NUM_CLS];
    logic [N_GRP-1:0]  req_cls [NUM_CLS];
    logic [DATA_W-1:0] rd_cls  [NUM_CLS];
    logic [N_GRP-1:0]  req_all;
    logic [N_GRP-1:0]  irq_q;

    assign src_cls[int'(CLS_DEV)] = src_dev;
    assign src_cls[int'(CLS_TMR)] = src_tmr;

    // One selector bank and one decoder per source class.
    generate
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            irq_sel_bank #(
                .N_SRC(N_SRC), .SEL_W(SEL_W), .DATA_W(DATA_W),
                .ADDR_W(ADDR_W), .BANK_ADDR(c)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
                .sel_flat(sel_cls[c]), .rd_word(rd_cls[c])
            );
            irq_src_decode #(
                .N_SRC(N_SRC), .SEL_W(SEL_W), .N_GRP(N_GRP)
            ) u_dec (
                .src(src_cls[c]), .sel_flat(sel_cls[c]), .grp_req(req_cls[c])
            );
        end
    endgenerate

    // Merge the group requests of all classes.
    always_comb begin
        req_all = '0;
        for (int c = 0; c < NUM_CLS; c++)
            req_all = req_all | req_cls[c];
    end

    // Read mux: the addressed class word, or zero for an unused address.
    always_comb begin
        cfg_rdata = '0;
        for (int c = 0; c < NUM_CLS; c++)
            if (cfg_addr == ADDR_W'(c))
                cfg_rdata = rd_cls[c];
    end

    // Output register: the merged requests, clean for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= req_all;
    end

    assign irq = irq_q;

    AST_IRQ_RESET: assert property (@(posedge clk)
        !rst_n |=> (irq == '0)) else $error("irq not cleared");               // R1
    AST_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] == 1'b0)) else $error("irq0 driven");                        // R6
    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_cls[0] == '0) && (sel_cls[1] == '0)) |=> (irq == '0))
        else $error("disabled map drives irq");                              // R4

    generate
        for (genvar k = 0; k < N_SRC; k++) begin : g_chk
            logic [SEL_W-1:0] dsel;
            assign dsel = sel_cls[int'(CLS_DEV)][k*SEL_W +: SEL_W];
            AST_DEV_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                (src_dev[k] && (dsel != '0) && (int'(dsel) < N_GRP)) |-> req_all[dsel])
                else $error("device source not routed");                     // R3
        end
    endgenerate
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  src_dev = '0;
    logic [7:0]  src_tmr = '0;
    logic [15:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_dev(src_dev), .src_tmr(src_tmr), .irq(irq)
    );

    // Vector fields: {dev map, tmr map, src_dev, src_tmr, expected irq}
    localparam logic [95:0] VEC [0:7] = '{
        {32'h0000_0000, 32'h0000_0000, 8'hFF, 8'hFF, 16'h0000}, // R4 all off
        {32'h0000_0300, 32'h0000_0000, 8'h04, 8'h00, 16'h0008}, // R3 dev src2 bits 11:8
        {32'h8765_4321, 32'h0000_0000, 8'hFF, 8'h00, 16'h01FE}, // R3 dev spread
        {32'h0000_0000, 32'hFEDC_BA98, 8'h00, 8'hFF, 16'hFF00}, // R3 tmr spread
        {32'h0000_0055, 32'h0000_0005, 8'h02, 8'h00, 16'h0020}, // R5 shared group 5
        {32'h8765_4321, 32'hFEDC_BA98, 8'h05, 8'h80, 16'h800A}, // R5 mixed classes
        {32'hF0F0_F0F0, 32'h0000_0000, 8'h55, 8'h00, 16'h0000}, // R4 only disabled ones high
        {32'hF0F0_F0F0, 32'h0000_0000, 8'hAA, 8'h00, 16'h8000}  // R5 four onto IRQ15
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 irq", {16'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_read_chk("R1 dev map", 2'd0, 32'h0);
        cfg_read_chk("R1 tmr map", 2'd1, 32'h0);
        check("R1 irq after release", {16'h0, irq}, 32'h0);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            cfg_write(2'd0, VEC[i][95:64]);
            cfg_write(2'd1, VEC[i][63:32]);
            cfg_read_chk("R2 dev readback", 2'd0, VEC[i][95:64]);
            cfg_read_chk("R2 tmr readback", 2'd1, VEC[i][63:32]);
            src_dev = VEC[i][31:24];
            src_tmr = VEC[i][23:16];
            @(negedge clk);
            check("R3/R4/R5 vector irq", {16'h0, irq}, {16'h0, VEC[i][15:0]});
            check("R6 irq0 low", {31'h0, irq[0]}, 32'h0);
            src_dev = '0; src_tmr = '0;
            @(negedge clk);
        end

        // R7: unused addresses
        cfg_write(2'd0, 32'h0000_0700);
        cfg_write(2'd1, 32'h0000_0000);
        src_dev = 8'h04;
        @(negedge clk);
        check("R3 src2 to IRQ7", {16'h0, irq}, 32'h0000_0080);
        cfg_write(2'd2, 32'hFFFF_FFFF);
        cfg_write(2'd3, 32'h1111_1111);
        cfg_read_chk("R7 addr2 reads 0", 2'd2, 32'h0);
        cfg_read_chk("R7 addr3 reads 0", 2'd3, 32'h0);
        cfg_read_chk("R7 dev map kept", 2'd0, 32'h0000_0700);
        cfg_read_chk("R7 tmr map kept", 2'd1, 32'h0);
        check("R7 irq kept", {16'h0, irq}, 32'h0000_0080);

        // R9: level hold, then release
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check("R9 held", {16'h0, irq}, 32'h0000_0080);
        end
        src_dev = 8'h00;
        #1;
        check("R9 before sample edge", {16'h0, irq}, 32'h0000_0080);
        @(negedge clk);
        check("R9 dropped", {16'h0, irq}, 32'h0);

        // R8: remap timing, source held high
        src_dev = 8'h04;
        @(negedge clk);
        check("R8 start", {16'h0, irq}, 32'h0000_0080);
        cfg_write(2'd0, 32'h0000_0C00);
        #1;
        check("R8 old map at load edge", {16'h0, irq}, 32'h0000_0080);
        @(negedge clk);
        check("R8 new map next edge", {16'h0, irq}, 32'h0000_1000);

        // R4: disable by writing selector 0 with source still high
        cfg_write(2'd0, 32'h0);
        @(negedge clk);
        check("R4 disabled source", {16'h0, irq}, 32'h0);

        // R1: reset clears map and output mid-run
        cfg_write(2'd1, 32'h0000_000F);
        src_tmr = 8'h01;
        @(negedge clk);
        check("R3 tmr src0 to IRQ15", {16'h0, irq}, 32'h0000_8000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq on reset", {16'h0, irq}, 32'h0);
        cfg_read_chk("R1 tmr map on reset", 2'd1, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays clear", {16'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule